// File: doc/BRIEF.md
# Externally Aligned Frame Sync Generator

This block produces a frame pulse and a multiframe pulse from a fast clock. There is one multiframe pulse for every four frame pulses. It also produces a small set of divided auxiliary clocks. All of these run freely until an external sync line shows a falling edge. One of three sync lines is chosen by a select input. When the chosen line falls, the frame and multiframe counters restart so that a new frame begins on the next cycle. An independence control decides whether the auxiliary dividers restart on the same event.

The block is clocked at twice the sync sampling rate. One UI is therefore two clock cycles, and half-UI offsets are one cycle. Every sync line keeps a short shift history. A per-line phase code picks which stage of that history the edge is taken from. The result is a detection that is coincident with the nominal point, half a UI early, half a UI late or one UI late. A rate control selects one of two frame lengths, matching the two sampling resolutions. The default parameters use short frames so that simulation stays fast. A real system would set frame lengths in the hundreds or thousands of UI.

Software writes one configuration byte through a one-cycle write strobe. The sync-line select is a separate input.

Top module: `frame_sync_aligner`

## Requirements
- R1: While `rst` is high, `fs_pulse`, `mfs_pulse` and every `aux_clk` bit are low. The configuration byte returns to zero. On the first clock edge after `rst` falls, `fs_pulse`, `mfs_pulse` and every `aux_clk` bit go high.
- R2: With configuration bit 6 at 0, `fs_pulse` rises every 2*FRAME_UI_LO cycles. With bit 6 at 1, it rises every 2*FRAME_UI_HI cycles.
- R3: Every high interval of `fs_pulse` and of `mfs_pulse` lasts exactly two clock cycles (one UI).
- R4: `mfs_pulse` rises together with every fourth `fs_pulse` rise, counting the frame that starts after reset or after a realignment as frame 0. It is never high while `fs_pulse` is low.
- R5: Let E be the first clock edge that samples the selected sync line low after it was high. Then `fs_pulse` rises on edge E+1+d. The offset d comes from that line's 2-bit phase code: 01 gives d=0 (half UI early), 00 gives d=1 (coincident), 11 gives d=2 (half UI late) and 10 gives d=3 (one UI late). Line 1 uses configuration bits 1:0, line 2 uses bits 3:2 and line 3 uses bits 5:4.
- R6: `sync_sel` values 0, 1 and 2 choose sync lines 1, 2 and 3. The value 3 chooses none. Edges on lines that are not chosen, and the phase codes of those lines, have no effect on any output.
- R7: A realignment also restarts the multiframe count: `mfs_pulse` rises on the same edge as the realigned `fs_pulse`.
- R8: With configuration bit 7 at 0, a realignment restarts every auxiliary divider i. From the edge where `fs_pulse` rises, `aux_clk[i]` is high for the first half of each period of AUX_BASE<<i cycles and low for the second half.
- R9: With configuration bit 7 at 1, a realignment leaves the phase of every `aux_clk` bit unchanged.
- R10: When `cfg_we` is high at a clock edge, `cfg_wdata` is captured on that edge and governs behaviour from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sync sampling rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte: [7] independence, [6] rate, [5:4]/[3:2]/[1:0] phase codes of lines 3/2/1 |
| sync_sel | input | 2 | Chosen sync line (0..2), 3 = none |
| sync_n | input | 3 | External sync lines, idle high, active falling edge |
| fs_pulse | output | 1 | Frame pulse |
| mfs_pulse | output | 1 | Multiframe pulse, one per four frames |
| aux_clk | output | NUM_AUX | Divided auxiliary clocks |

## Verification
A wrong tap choice or a stale history shows at the ports as a frame pulse that is one or more cycles off its predicted edge. It is visible on the very first pulse after the sync edge, so every phase code is timed against an exact cycle. A drifting frame or multiframe counter, or a restart that misses the multiframe counter, shows within one multiframe as a pulse rising at the wrong cycle or not at all. A divider that restarts when it should not, or fails to restart when it should, shows within a few cycles of the event, because the auxiliary outputs are compared against their predicted phase right after each alignment.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  // Phase code per sync line; encoding fixed by the configuration byte.
  typedef enum logic [1:0] {
    PH_COIN       = 2'b00,
    PH_EARLY_HALF = 2'b01,
    PH_LATE_ONE   = 2'b10,
    PH_LATE_HALF  = 2'b11
  } phase_e;

  typedef struct packed {
    logic   indep;
    logic   fast_rate;
    phase_e ph3;
    phase_e ph2;
    phase_e ph1;
  } cfg_t;

  // Number of half-UI history taps a line can be read from.
  localparam int TAPS = 4;

  // Tap index (half-UI delay past the earliest possible detection).
  function automatic logic [1:0] tap_of(phase_e p);
    case (p)
      PH_EARLY_HALF: tap_of = 2'd0;
      PH_COIN:       tap_of = 2'd1;
      PH_LATE_HALF:  tap_of = 2'd2;
      default:       tap_of = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/fsg_sync_tap.sv
module fsg_sync_tap #(
  parameter int TAPS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sync_i,
  output logic [TAPS-1:0] fall_o
);
  // hist[0] is the newest sample; idle level is high.
  logic [TAPS:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '1;
    else     hist <= {hist[TAPS-1:0], sync_i};
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_fall
    assign fall_o[k] = hist[k+1] & ~hist[k];
  end
endmodule

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr #(
  parameter int LEN_LO    = 48,
  parameter int LEN_HI    = 144,
  parameter int MF_FRAMES = 4,
  parameter int PULSE     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fast,
  input  logic realign,
  output logic fs_o,
  output logic mfs_o
);
  localparam int LEN_MAX = (LEN_HI > LEN_LO) ? LEN_HI : LEN_LO;
  localparam int CNT_W   = $clog2(LEN_MAX);
  localparam int MF_W    = $clog2(MF_FRAMES);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(LEN_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(LEN_HI - 1);
  localparam logic [CNT_W-1:0] PULSE_C = CNT_W'(PULSE);
  localparam logic [MF_W-1:0]  MF_LAST = MF_W'(MF_FRAMES - 1);

  logic [CNT_W-1:0] fcnt, fcnt_nx;
  logic [MF_W-1:0]  mcnt, mcnt_nx;
  logic             wrap;

  always_comb begin
    wrap = fcnt >= (fast ? LAST_HI : LAST_LO);
    if (realign) begin
      fcnt_nx = '0;
      mcnt_nx = '0;
    end else if (wrap) begin
      fcnt_nx = '0;
      mcnt_nx = (mcnt == MF_LAST) ? '0 : mcnt + 1'b1;
    end else begin
      fcnt_nx = fcnt + 1'b1;
      mcnt_nx = mcnt;
    end
  end

  // Reset parks the counters on the last slot so frame 0 opens on the first edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt  <= LAST_LO;
      mcnt  <= MF_LAST;
      fs_o  <= 1'b0;
      mfs_o <= 1'b0;
    end else begin
      fcnt  <= fcnt_nx;
      mcnt  <= mcnt_nx;
      fs_o  <= fcnt_nx < PULSE_C;
      mfs_o <= (mcnt_nx == '0) && (fcnt_nx < PULSE_C);
    end
  end
endmodule

// File: rtl/fsg_aux_div.sv
module fsg_aux_div #(
  parameter int PERIOD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic clk_o
);
  localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);
  localparam logic [W-1:0] HALF = W'(PERIOD / 2);

  logic [W-1:0] cnt, cnt_nx;

  always_comb begin
    if (restart || cnt == LAST) cnt_nx = '0;
    else                        cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= LAST;
      clk_o <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      clk_o <= cnt_nx < HALF;
    end
  end
endmodule

// File: rtl/frame_sync_aligner.sv
module frame_sync_aligner #(
  parameter int FRAME_UI_LO = 24,
  parameter int FRAME_UI_HI = 72,
  parameter int MF_FRAMES   = 4,
  parameter int NUM_AUX     = 3,
  parameter int AUX_BASE    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  input  logic [1:0]         sync_sel,
  input  logic [2:0]         sync_n,
  output logic               fs_pulse,
  output logic               mfs_pulse,
  output logic [NUM_AUX-1:0] aux_clk
);
  import fsg_pkg::*;

  localparam int NUM_SYNC = 3;
  localparam int LEN_LO   = 2 * FRAME_UI_LO;
  localparam int LEN_HI   = 2 * FRAME_UI_HI;

  cfg_t            cfg_q;
  phase_e          ph [NUM_SYNC];
  logic [TAPS-1:0] fall [NUM_SYNC];
  logic            align_evt;
  logic            indep_q;
  logic            aux_restart;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= cfg_t'(8'h00);
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  assign ph[0]   = cfg_q.ph1;
  assign ph[1]   = cfg_q.ph2;
  assign ph[2]   = cfg_q.ph3;
  assign indep_q = cfg_q.indep;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_line
    fsg_sync_tap #(.TAPS(TAPS)) u_tap (
      .clk    (clk),
      .rst    (rst),
      .sync_i (sync_n[g]),
      .fall_o (fall[g])
    );
  end

  // Only the chosen line, read at its own phase tap, can realign.
  always_comb begin
    align_evt = 1'b0;
    for (int i = 0; i < NUM_SYNC; i++) begin
      if (sync_sel == 2'(i)) align_evt = fall[i][tap_of(ph[i])];
    end
  end

  assign aux_restart = align_evt & ~indep_q;

  fsg_frame_ctr #(
    .LEN_LO    (LEN_LO),
    .LEN_HI    (LEN_HI),
    .MF_FRAMES (MF_FRAMES),
    .PULSE     (2)
  ) u_frame (
    .clk     (clk),
    .rst     (rst),
    .fast    (cfg_q.fast_rate),
    .realign (align_evt),
    .fs_o    (fs_pulse),
    .mfs_o   (mfs_pulse)
  );

  for (genvar a = 0; a < NUM_AUX; a++) begin : g_aux
    fsg_aux_div #(.PERIOD(AUX_BASE << a)) u_div (
      .clk     (clk),
      .rst     (rst),
      .restart (aux_restart),
      .clk_o   (aux_clk[a])
    );
  end
endmodule

// File: rtl/frame_sync_aligner_chk.sv
module frame_sync_aligner_chk #(
  parameter int NUM_AUX = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               fs,
  input logic               mfs,
  input logic [NUM_AUX-1:0] aux,
  input logic               evt,
  input logic               indep
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs are quiet after a reset edge
  always @(posedge clk) begin
    if (rst_d) begin
      p_reset_quiet_r1: assert (!fs && !mfs && aux == '0)
        else $error("outputs active right after reset");
    end
  end

  // R3: frame pulse lasts exactly two cycles
  p_fs_two_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fs) |=> fs);
  p_fs_end_r3: assert property (@(posedge clk) disable iff (rst)
    (fs && $past(fs)) |=> !fs);
  p_mfs_end_r3: assert property (@(posedge clk) disable iff (rst)
    (mfs && $past(mfs)) |=> !mfs);

  // R4: multiframe pulse only inside a frame pulse
  p_mfs_in_fs_r4: assert property (@(posedge clk) disable iff (rst)
    mfs |-> fs);

  // R5 and R7: a detected edge opens frame 0 of a multiframe next cycle
  p_realign_r5: assert property (@(posedge clk) disable iff (rst)
    evt |=> (fs && mfs));

  // R8: dependent mode restarts every divider high
  p_aux_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (evt && !indep) |=> (&aux));
endmodule

bind frame_sync_aligner frame_sync_aligner_chk #(.NUM_AUX(NUM_AUX)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .fs    (fs_pulse),
  .mfs   (mfs_pulse),
  .aux   (aux_clk),
  .evt   (align_evt),
  .indep (indep_q)
);

// File: tb/frame_sync_aligner_tb.sv
module frame_sync_aligner_tb;
  localparam int UI_LO    = 24;
  localparam int UI_HI    = 72;
  localparam int L_LO     = 2 * UI_LO;
  localparam int L_HI     = 2 * UI_HI;
  localparam int NUM_AUX  = 3;
  localparam int AUX_BASE = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfg_we = 1'b0;
  logic [7:0]         cfg_wdata = 8'h00;
  logic [1:0]         sync_sel = 2'd0;
  logic [2:0]         sync_n = 3'b111;
  logic               fs_pulse, mfs_pulse;
  logic [NUM_AUX-1:0] aux_clk;

  frame_sync_aligner #(
    .FRAME_UI_LO (UI_LO),
    .FRAME_UI_HI (UI_HI),
    .MF_FRAMES   (4),
    .NUM_AUX     (NUM_AUX),
    .AUX_BASE    (AUX_BASE)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .sync_sel  (sync_sel),
    .sync_n    (sync_n),
    .fs_pulse  (fs_pulse),
    .mfs_pulse (mfs_pulse),
    .aux_clk   (aux_clk)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_checks = 0;
  int    n_err    = 0;
  int    exp_fs[$];
  int    exp_mfs[$];
  string cur_tag = "R1";
  int    last_fs, fidx, aux_ref, cur_len;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops predicted rise cycles and times pulse widths.
  logic fs_prev = 1'b0, mfs_prev = 1'b0;
  int   fs_run = 0, mfs_run = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (fs_pulse && !fs_prev) begin
        if (exp_fs.size() == 0) check(1'b0, cur_tag, "unexpected fs rise", cyc, -1);
        else begin
          int e;
          e = exp_fs.pop_front();
          check(cyc == e, cur_tag, "fs rise cycle", cyc, e);
        end
      end
      if (mfs_pulse && !mfs_prev) begin
        if (exp_mfs.size() == 0) check(1'b0, "R4/R7", "unexpected mfs rise", cyc, -1);
        else begin
          int e;
          e = exp_mfs.pop_front();
          check(cyc == e, "R4/R7", "mfs rise cycle", cyc, e);
        end
      end
      if (mfs_pulse && !fs_pulse) check(1'b0, "R4", "mfs without fs", cyc, 0);
      if (fs_pulse) fs_run++;
      else if (fs_prev) begin
        check(fs_run == 2, "R3", "fs width", fs_run, 2);
        fs_run = 0;
      end
      if (mfs_pulse) mfs_run++;
      else if (mfs_prev) begin
        check(mfs_run == 2, "R3", "mfs width", mfs_run, 2);
        mfs_run = 0;
      end
      fs_prev  = fs_pulse;
      mfs_prev = mfs_pulse;
    end
  end

  // Driver side of the scoreboard
  task automatic push_start(input int ev);
    last_fs = ev;
    fidx    = 0;
    exp_fs.push_back(ev);
    exp_mfs.push_back(ev);
  endtask

  task automatic push_next();
    last_fs = last_fs + cur_len;
    fidx    = (fidx + 1) % 4;
    exp_fs.push_back(last_fs);
    if (fidx == 0) exp_mfs.push_back(last_fs);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic check_aux(input string req);
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < NUM_AUX; i++) begin
        int p;
        bit e;
        p = AUX_BASE << i;
        e = ((cyc - aux_ref) % p) < (p / 2);
        check(aux_clk[i] == e, req, $sformatf("aux_clk[%0d] at cycle %0d", i, cyc),
              int'(aux_clk[i]), int'(e));
      end
      @(negedge clk);
    end
  endtask

  // One alignment: write cfg, drop line idx, predict the pulses that follow.
  task automatic align(input logic [7:0] cfg, input logic [1:0] sel, input int idx,
                       input int d, input int nf, input string tag);
    int n, ev;
    wait_cyc(last_fs + 5);
    cur_tag  = tag;
    sync_sel = sel;
    write_cfg(cfg);
    cur_len  = cfg[6] ? L_HI : L_LO;
    n = cyc;
    sync_n[idx] = 1'b0;
    ev = n + 2 + d;
    push_start(ev);
    for (int k = 0; k < nf; k++) push_next();
    if (!cfg[7]) aux_ref = ev;
    wait_cyc(ev);
    check_aux(cfg[7] ? "R9" : "R8");
    sync_n[idx] = 1'b1;
  endtask

  // A falling edge that must not realign (R6).
  task automatic ignored_edge(input logic [7:0] cfg, input logic [1:0] sel,
                              input int idx);
    wait_cyc(last_fs + 5);
    cur_tag  = "R6";
    sync_sel = sel;
    write_cfg(cfg);
    sync_n[idx] = 1'b0;
    push_next();
    repeat (10) @(negedge clk);
    check_aux("R6");
    sync_n[idx] = 1'b1;
  endtask

  initial begin
    cur_len = L_LO;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check(fs_pulse == 1'b0, "R1", "fs in reset", int'(fs_pulse), 0);
    check(mfs_pulse == 1'b0, "R1", "mfs in reset", int'(mfs_pulse), 0);
    check(aux_clk == '0, "R1", "aux in reset", int'(aux_clk), 0);
    rst = 1'b0;
    push_start(cyc + 1);
    aux_ref = cyc + 1;
    push_next();
    @(negedge clk);
    check(aux_clk == '1, "R1", "aux after reset", int'(aux_clk), (1 << NUM_AUX) - 1);

    // R5/R2/R4: coincident on line 1, four frames to see multiframe spacing
    align(8'h00, 2'd0, 0, 1, 4, "R5 code00 R2 R4");
    align(8'h01, 2'd0, 0, 0, 1, "R5 code01");
    align(8'h03, 2'd0, 0, 2, 1, "R5 code11");
    align(8'h02, 2'd0, 0, 3, 1, "R5 code10");
    // R6: line 2 at code 10, other fields set to values that would differ
    align(8'h39, 2'd1, 1, 3, 1, "R6 line2 R5");
    // R6: line 3 at code 01
    align(8'h1E, 2'd2, 2, 0, 1, "R6 line3 R5");
    // R9: independent mode, dividers keep phase
    align(8'h80, 2'd0, 0, 1, 1, "R9 R7");
    // R6: unselected line and select value 3 are ignored
    ignored_edge(8'h00, 2'd0, 1);
    ignored_edge(8'h00, 2'd3, 0);
    // R10/R2: fast rate takes effect after the write; four frames
    align(8'h40, 2'd0, 0, 1, 4, "R10 R2 fast");

    wait_cyc(last_fs + 5);
    check(exp_fs.size() == 0, "R2", "unmet fs predictions", exp_fs.size(), 0);
    check(exp_mfs.size() == 0, "R4", "unmet mfs predictions", exp_mfs.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule